// File: doc/BRIEF.md
# Parallel Bus Handshake Monitor

This block watches the control lines of a shared parallel bus and never drives them. On every rising clock edge it samples the cycle-framing line, the initiator-ready and target-ready lines, the target stop and device-select lines, and the 4-bit command/byte-enable field. All of these are active-high internal booleans. From these samples it follows each transaction from idle through its address phase and data phases, and back to idle. It also allows a new address phase to follow the last data phase directly.

For each transaction it counts completed data transfers. It also counts wait cycles, split by which side inserted them: the initiator or the target. When the transaction ends, it raises a one-clock done pulse and presents the counts. It decodes the command taken in the address phase. When either side breaks a commitment rule, it records the first violation in a sticky error flag with a cause code, which holds until software or a neighbouring block clears it synchronously. The monitor is meant to sit beside a bus interface in simulation or in silicon, as a protocol watchdog.

Top module: `bus_handshake_checker`

## Requirements
- R1: The address phase is the first clock on which `frame` is sampled high while the monitor is idle. `cbe` is captured there into `cmd_code`. `cmd_kind` then reads 0 for 4'b0000 (interrupt acknowledge), 1 for 4'b0001 (broadcast), 2 for 4'b0010 (I/O read), 3 for 4'b0011 (I/O write), 4 for 4'b0100 or 4'b0101 (reserved), and 5 for any other value.
- R2: Every clock after the address phase is a data-phase clock. A transfer is counted on each data-phase clock where `irdy` and `trdy` are both high.
- R3: On a data-phase clock with `frame` high and `irdy` low, one initiator wait is counted. On one with `irdy` high and both `trdy` and `stop` low, one target wait is counted.
- R4: A data phase that completes while `frame` is low ends the transaction. After that edge, `txn_done` is high for exactly one clock. At the same time, `txn_xfers`, `txn_wait_master` and `txn_wait_target` hold the totals from the address phase to that clock, including the final clock.
- R5: `frame` may be high on the clock right after a final completion (back-to-back). This starts a new address phase and raises no error.
- R6: Once `irdy` has been sampled high in a data phase that has not completed, a later clock of the same phase may not show a different `frame` or `irdy`. If it does, the error cause becomes 1.
- R7: Once `trdy` or `stop` has been sampled high in a data phase that has not completed, a later clock of the same phase may not show a different `devsel`, `trdy` or `stop`. If it does, the error cause becomes 2.
- R8: An address phase with `cbe` equal to 4'b0100 or 4'b0101 sets the error cause to 3. Other command values raise no error.
- R9: When the monitor is idle, a clock with `irdy` high and `frame` low sets the error cause to 4.
- R10: `err_cause` keeps the first violation, and `err_flag` stays high, until a clear. If several violations occur on one clock, the lowest nonzero code is kept.
- R11: `clr_err` high at a clock edge sets `err_cause` to 0 and `err_flag` low after that edge. It takes priority over a violation on the same clock.
- R12: Each of the three counts is `CNT_W` (16) bits wide and stops at its all-ones value instead of wrapping.
- R13: A data phase with `irdy` and `stop` high and `trdy` low completes without a transfer. If `frame` is low on that clock, the transaction ends with a `txn_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_err | input | 1 | Synchronous clear of the latched error |
| frame | input | 1 | Cycle-framing line, high while the initiator owns the bus |
| irdy | input | 1 | Initiator ready |
| trdy | input | 1 | Target ready |
| stop | input | 1 | Target requests termination |
| devsel | input | 1 | Target has claimed the cycle |
| cbe | input | 4 | Command in the address phase, byte enables afterwards |
| cmd_code | output | 4 | Command captured in the last address phase |
| cmd_kind | output | 3 | Decoded class of `cmd_code` (R1) |
| txn_done | output | 1 | One-clock pulse after a transaction ends |
| txn_xfers | output | CNT_W | Transfers in the last finished transaction |
| txn_wait_master | output | CNT_W | Initiator waits in the last finished transaction |
| txn_wait_target | output | CNT_W | Target waits in the last finished transaction |
| err_flag | output | 1 | A violation is latched |
| err_cause | output | 3 | Latched cause: 0 none, 1 initiator hold, 2 target hold, 3 reserved command, 4 ready while idle |

## Verification
The hardest cases to reach are the hold violations. They need a side to commit inside a phase that does not complete, and then change a line one clock later. On the target side this only happens when `irdy` is low, because otherwise the phase would complete. The directed stimulus therefore builds the target commit with `irdy` held low, then drops `trdy` or `devsel`. It does the same with `stop` held high, ending in a stop-terminated final phase that carries no transfer. The counter limit is reached by one burst longer than the all-ones value.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  localparam int CMD_W = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } bus_st_t;

  typedef enum logic [2:0] {
    CK_INTACK  = 3'd0,
    CK_BCAST   = 3'd1,
    CK_IORD    = 3'd2,
    CK_IOWR    = 3'd3,
    CK_RSVD    = 3'd4,
    CK_OTHER   = 3'd5
  } cmd_kind_t;

  typedef enum logic [2:0] {
    EC_NONE     = 3'd0,
    EC_MHOLD    = 3'd1,
    EC_THOLD    = 3'd2,
    EC_RSVD     = 3'd3,
    EC_IDLERDY  = 3'd4
  } err_code_t;

  // Map a raw command nibble onto its class.
  function automatic cmd_kind_t classify_cmd(input logic [CMD_W-1:0] c);
    case (c)
      4'b0000:          return CK_INTACK;
      4'b0001:          return CK_BCAST;
      4'b0010:          return CK_IORD;
      4'b0011:          return CK_IOWR;
      4'b0100, 4'b0101: return CK_RSVD;
      default:          return CK_OTHER;
    endcase
  endfunction

  // Lowest code wins when several rules break on one clock.
  function automatic err_code_t first_cause(input logic m_hold, input logic t_hold,
                                            input logic rsvd, input logic idle_rdy);
    if (m_hold)   return EC_MHOLD;
    if (t_hold)   return EC_THOLD;
    if (rsvd)     return EC_RSVD;
    if (idle_rdy) return EC_IDLERDY;
    return EC_NONE;
  endfunction

endpackage

// File: rtl/bhc_phase_fsm.sv
module bhc_phase_fsm
  import bhc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame,
  input  logic             irdy,
  input  logic             trdy,
  input  logic             stop,
  input  logic [CMD_W-1:0] cbe,
  output logic             in_data,
  output logic             addr_phase,
  output logic             phase_end,
  output logic             xfer_beat,
  output logic             final_end,
  output logic             abandon,
  output logic             wait_m,
  output logic             wait_t,
  output logic             idle_irdy,
  output logic             rsvd_addr,
  output logic [CMD_W-1:0] cmd_q,
  output cmd_kind_t        cmd_kind
);

  bus_st_t st_q, st_d;

  assign in_data    = (st_q == ST_DATA);
  assign addr_phase = !in_data && frame;
  assign phase_end  = in_data && irdy && (trdy || stop);
  assign xfer_beat  = in_data && irdy && trdy;
  assign final_end  = phase_end && !frame;
  assign abandon    = in_data && !frame && !irdy;
  assign wait_m     = in_data && frame && !irdy;
  assign wait_t     = in_data && irdy && !trdy && !stop;
  assign idle_irdy  = !in_data && !frame && irdy;
  assign rsvd_addr  = addr_phase && (classify_cmd(cbe) == CK_RSVD);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (frame) st_d = ST_DATA;
      ST_DATA: if (final_end || abandon) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cmd_q <= '0;
    end else begin
      st_q <= st_d;
      if (addr_phase) cmd_q <= cbe;
    end
  end

  assign cmd_kind = classify_cmd(cmd_q);

endmodule

// File: rtl/bhc_commit_watch.sv
module bhc_commit_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic in_data,
  input  logic phase_end,
  input  logic abandon,
  input  logic frame,
  input  logic irdy,
  input  logic trdy,
  input  logic stop,
  input  logic devsel,
  output logic m_com,
  output logic t_com,
  output logic m_viol,
  output logic t_viol
);

  logic p_frame, p_irdy, p_trdy, p_stop, p_devsel;
  logic phase_closes;

  assign phase_closes = !in_data || phase_end || abandon;

  assign m_viol = in_data && m_com && ((frame != p_frame) || (irdy != p_irdy));
  assign t_viol = in_data && t_com &&
                  ((devsel != p_devsel) || (trdy != p_trdy) || (stop != p_stop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_com    <= 1'b0;
      t_com    <= 1'b0;
      p_frame  <= 1'b0;
      p_irdy   <= 1'b0;
      p_trdy   <= 1'b0;
      p_stop   <= 1'b0;
      p_devsel <= 1'b0;
    end else begin
      p_frame  <= frame;
      p_irdy   <= irdy;
      p_trdy   <= trdy;
      p_stop   <= stop;
      p_devsel <= devsel;
      if (phase_closes) begin
        m_com <= 1'b0;
        t_com <= 1'b0;
      end else begin
        m_com <= m_com || irdy;
        t_com <= t_com || trdy || stop;
      end
    end
  end

endmodule

// File: rtl/bhc_txn_counters.sv
module bhc_txn_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic             xfer_beat,
  input  logic             wait_m,
  input  logic             wait_t,
  input  logic             final_end,
  output logic             txn_done,
  output logic [CNT_W-1:0] txn_xfers,
  output logic [CNT_W-1:0] txn_wait_master,
  output logic [CNT_W-1:0] txn_wait_target
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Add one when asked, but hold at the ceiling.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v, input logic en);
    if (en && (v != CNT_MAX)) return v + 1'b1;
    return v;
  endfunction

  logic [CNT_W-1:0] acc_x, acc_m, acc_t;
  logic [CNT_W-1:0] nxt_x, nxt_m, nxt_t;

  assign nxt_x = sat_inc(acc_x, xfer_beat);
  assign nxt_m = sat_inc(acc_m, wait_m);
  assign nxt_t = sat_inc(acc_t, wait_t);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_x           <= '0;
      acc_m           <= '0;
      acc_t           <= '0;
      txn_done        <= 1'b0;
      txn_xfers       <= '0;
      txn_wait_master <= '0;
      txn_wait_target <= '0;
    end else begin
      txn_done <= final_end;
      if (addr_phase) begin
        acc_x <= '0;
        acc_m <= '0;
        acc_t <= '0;
      end else begin
        acc_x <= nxt_x;
        acc_m <= nxt_m;
        acc_t <= nxt_t;
      end
      if (final_end) begin
        txn_xfers       <= nxt_x;
        txn_wait_master <= nxt_m;
        txn_wait_target <= nxt_t;
      end
    end
  end

endmodule

// File: rtl/bus_handshake_checker.sv
module bus_handshake_checker
  import bhc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_err,
  input  logic             frame,
  input  logic             irdy,
  input  logic             trdy,
  input  logic             stop,
  input  logic             devsel,
  input  logic [3:0]       cbe,
  output logic [3:0]       cmd_code,
  output logic [2:0]       cmd_kind,
  output logic             txn_done,
  output logic [CNT_W-1:0] txn_xfers,
  output logic [CNT_W-1:0] txn_wait_master,
  output logic [CNT_W-1:0] txn_wait_target,
  output logic             err_flag,
  output logic [2:0]       err_cause
);

  // Named events, shared with the bound checker.
  logic      in_data, addr_phase, phase_end, xfer_beat, final_end, abandon;
  logic      wait_m, wait_t, idle_irdy, rsvd_addr;
  logic      m_com, t_com, m_viol, t_viol;
  cmd_kind_t kind_w;
  err_code_t cause_now, err_q;

  bhc_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame      (frame),
    .irdy       (irdy),
    .trdy       (trdy),
    .stop       (stop),
    .cbe        (cbe),
    .in_data    (in_data),
    .addr_phase (addr_phase),
    .phase_end  (phase_end),
    .xfer_beat  (xfer_beat),
    .final_end  (final_end),
    .abandon    (abandon),
    .wait_m     (wait_m),
    .wait_t     (wait_t),
    .idle_irdy  (idle_irdy),
    .rsvd_addr  (rsvd_addr),
    .cmd_q      (cmd_code),
    .cmd_kind   (kind_w)
  );

  bhc_commit_watch u_commit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_data   (in_data),
    .phase_end (phase_end),
    .abandon   (abandon),
    .frame     (frame),
    .irdy      (irdy),
    .trdy      (trdy),
    .stop      (stop),
    .devsel    (devsel),
    .m_com     (m_com),
    .t_com     (t_com),
    .m_viol    (m_viol),
    .t_viol    (t_viol)
  );

  bhc_txn_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr_phase      (addr_phase),
    .xfer_beat       (xfer_beat),
    .wait_m          (wait_m),
    .wait_t          (wait_t),
    .final_end       (final_end),
    .txn_done        (txn_done),
    .txn_xfers       (txn_xfers),
    .txn_wait_master (txn_wait_master),
    .txn_wait_target (txn_wait_target)
  );

  assign cause_now = first_cause(m_viol, t_viol, rsvd_addr, idle_irdy);

  always_ff @(posedge clk) begin
    if (!rst_n)                                   err_q <= EC_NONE;
    else if (clr_err)                             err_q <= EC_NONE;
    else if (err_q == EC_NONE && cause_now != EC_NONE) err_q <= cause_now;
  end

  assign cmd_kind  = kind_w;
  assign err_cause = err_q;
  assign err_flag  = (err_q != EC_NONE);

endmodule

// File: rtl/bhc_checker.sv
module bhc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_err,
  input logic       txn_done,
  input logic       err_flag,
  input logic [2:0] err_cause,
  input logic       m_viol,
  input logic       t_viol,
  input logic       rsvd_addr,
  input logic       idle_irdy,
  input logic       in_data,
  input logic       m_com,
  input logic       t_com
);

  // R4
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |=> !txn_done);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr_err) |=> $stable(err_cause));

  // R10
  err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_cause <= 3'd4);

  // R11
  clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (err_cause == 3'd0 && !err_flag));

  // R6
  mhold_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_viol && !err_flag && !clr_err) |=> (err_cause == 3'd1));

  // R7
  thold_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_viol && !m_viol && !err_flag && !clr_err) |=> (err_cause == 3'd2));

  // R8
  rsvd_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsvd_addr && !m_viol && !t_viol && !err_flag && !clr_err) |=> (err_cause == 3'd3));

  // R9
  idle_rdy_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_irdy && !err_flag && !clr_err) |=> (err_cause == 3'd4));

  // R6
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_data |-> (!m_com && !t_com));

endmodule

bind bus_handshake_checker bhc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_err   (clr_err),
  .txn_done  (txn_done),
  .err_flag  (err_flag),
  .err_cause (err_cause),
  .m_viol    (m_viol),
  .t_viol    (t_viol),
  .rsvd_addr (rsvd_addr),
  .idle_irdy (idle_irdy),
  .in_data   (in_data),
  .m_com     (m_com),
  .t_com     (t_com)
);

// File: tb/sim_bus_handshake_checker.sv
`timescale 1ns/1ps
module sim_bus_handshake_checker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_err = 1'b0;
  logic        frame = 1'b0, irdy = 1'b0, trdy = 1'b0, stop = 1'b0, devsel = 1'b0;
  logic [3:0]  cbe = 4'd0;
  logic [3:0]  cmd_code;
  logic [2:0]  cmd_kind;
  logic        txn_done;
  logic [15:0] txn_xfers, txn_wait_master, txn_wait_target;
  logic        err_flag;
  logic [2:0]  err_cause;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_handshake_checker u0 (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
    .frame(frame), .irdy(irdy), .trdy(trdy), .stop(stop), .devsel(devsel), .cbe(cbe),
    .cmd_code(cmd_code), .cmd_kind(cmd_kind), .txn_done(txn_done),
    .txn_xfers(txn_xfers), .txn_wait_master(txn_wait_master),
    .txn_wait_target(txn_wait_target), .err_flag(err_flag), .err_cause(err_cause)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive one clock of bus state, then look just after the edge.
  task automatic cyc(input logic f, input logic i, input logic t, input logic s,
                     input logic d, input logic [3:0] c, input logic clr = 1'b0);
    @(negedge clk);
    frame = f; irdy = i; trdy = t; stop = s; devsel = d; cbe = c; clr_err = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic clr = 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, clr);
  endtask

  task automatic t_reset;
    check("R10", "reset err_cause", err_cause, 0);
    check("R10", "reset err_flag", err_flag, 0);
    check("R4", "reset txn_done", txn_done, 0);
    check("R2", "reset txn_xfers", txn_xfers, 0);
  endtask

  task automatic t_single;
    cyc(1, 0, 0, 0, 0, 4'b0010);
    check("R4", "no done after addr", txn_done, 0);
    cyc(0, 1, 1, 0, 1, 4'hF);
    check("R4", "single done", txn_done, 1);
    check("R2", "single xfers", txn_xfers, 1);
    check("R1", "io read code", cmd_code, 2);
    check("R1", "io read kind", cmd_kind, 2);
    idle();
    check("R4", "done one clock", txn_done, 0);
    check("R9", "no err after single", err_cause, 0);
  endtask

  task automatic t_burst;
    cyc(1, 0, 0, 0, 0, 4'b0011);
    for (int k = 0; k < 3; k++) cyc(1, 1, 1, 0, 1, 4'h0);
    cyc(0, 1, 1, 0, 1, 4'h0);
    check("R2", "burst xfers", txn_xfers, 4);
    check("R3", "burst master waits", txn_wait_master, 0);
    check("R3", "burst target waits", txn_wait_target, 0);
    check("R1", "io write kind", cmd_kind, 3);
    idle();
  endtask

  task automatic t_waits;
    cyc(1, 0, 0, 0, 0, 4'b0000);
    cyc(1, 0, 0, 0, 1, 4'h0);   // initiator wait
    cyc(1, 1, 0, 0, 1, 4'h0);   // target wait, initiator commits
    cyc(1, 1, 0, 0, 1, 4'h0);   // target wait
    cyc(1, 1, 1, 0, 1, 4'h0);   // transfer
    cyc(1, 0, 1, 0, 1, 4'h0);   // initiator wait, target commits
    cyc(1, 1, 1, 0, 1, 4'h0);   // transfer
    cyc(0, 1, 1, 0, 1, 4'h0);   // final transfer
    check("R2", "wait burst xfers", txn_xfers, 3);
    check("R3", "initiator waits", txn_wait_master, 2);
    check("R3", "target waits", txn_wait_target, 2);
    check("R6", "legal holds no error", err_cause, 0);
    check("R1", "intack kind", cmd_kind, 0);
    idle();
  endtask

  task automatic t_b2b;
    cyc(1, 0, 0, 0, 0, 4'b0001);
    cyc(0, 1, 1, 0, 1, 4'h0);
    check("R4", "b2b first done", txn_done, 1);
    check("R1", "broadcast kind", cmd_kind, 1);
    cyc(1, 0, 0, 0, 0, 4'b0011);
    check("R5", "b2b second addr no error", err_cause, 0);
    check("R4", "b2b done cleared", txn_done, 0);
    cyc(1, 1, 1, 0, 1, 4'h0);
    cyc(0, 1, 1, 0, 1, 4'h0);
    check("R5", "b2b second done", txn_done, 1);
    check("R5", "b2b second xfers", txn_xfers, 2);
    check("R5", "b2b second cmd", cmd_code, 3);
    check("R5", "b2b no error", err_cause, 0);
    idle();
  endtask

  task automatic t_mhold;
    cyc(1, 0, 0, 0, 0, 4'b0010);
    cyc(1, 1, 0, 0, 1, 4'h0);
    cyc(1, 0, 0, 0, 1, 4'h0);   // irdy withdrawn
    check("R6", "irdy withdrawn cause", err_cause, 1);
    check("R6", "irdy withdrawn flag", err_flag, 1);
    cyc(0, 1, 1, 0, 1, 4'h0);
    idle();
    check("R10", "cause sticky", err_cause, 1);
    idle(1'b1);
    check("R11", "clear", err_cause, 0);
    cyc(1, 0, 0, 0, 0, 4'b0010);
    cyc(1, 1, 0, 0, 1, 4'h0);
    cyc(0, 1, 0, 0, 1, 4'h0);   // frame dropped while waiting
    check("R6", "frame dropped cause", err_cause, 1);
    cyc(0, 1, 1, 0, 1, 4'h0);
    idle(1'b1);
  endtask

  task automatic t_thold;
    cyc(1, 0, 0, 0, 0, 4'b0011);
    cyc(1, 0, 1, 0, 1, 4'h0);
    cyc(1, 0, 0, 0, 1, 4'h0);   // trdy withdrawn
    check("R7", "trdy withdrawn cause", err_cause, 2);
    cyc(0, 1, 1, 0, 1, 4'h0);
    idle(1'b1);
    check("R11", "clear after target", err_cause, 0);
    cyc(1, 0, 0, 0, 0, 4'b0010);
    cyc(1, 0, 0, 1, 1, 4'h0);   // stop commits
    cyc(1, 0, 0, 1, 0, 4'h0);   // devsel withdrawn
    check("R7", "devsel withdrawn cause", err_cause, 2);
    cyc(0, 1, 0, 1, 0, 4'h0);   // stop-terminated final phase
    check("R13", "stop end done", txn_done, 1);
    check("R13", "stop end no transfer", txn_xfers, 0);
    idle(1'b1);
  endtask

  task automatic t_rsvd;
    cyc(1, 0, 0, 0, 0, 4'b0100);
    check("R8", "cmd 0100 cause", err_cause, 3);
    check("R1", "cmd 0100 kind", cmd_kind, 4);
    cyc(0, 1, 1, 0, 1, 4'h0);
    idle(1'b1);
    cyc(1, 0, 0, 0, 0, 4'b0101);
    check("R8", "cmd 0101 cause", err_cause, 3);
    cyc(0, 1, 1, 0, 1, 4'h0);
    idle(1'b1);
    cyc(1, 0, 0, 0, 0, 4'b0110);
    check("R8", "cmd 0110 no error", err_cause, 0);
    check("R1", "cmd 0110 kind", cmd_kind, 5);
    cyc(0, 1, 1, 0, 1, 4'h0);
    idle();
  endtask

  task automatic t_idle_rdy;
    cyc(0, 1, 0, 0, 0, 4'h0);
    check("R9", "irdy while idle", err_cause, 4);
    cyc(1, 0, 0, 0, 0, 4'b0100);
    check("R10", "first cause kept", err_cause, 4);
    cyc(0, 1, 1, 0, 1, 4'h0);
    idle();
    cyc(0, 1, 0, 0, 0, 4'h0, 1'b1);
    check("R11", "clear beats violation", err_cause, 0);
    idle();
    check("R11", "still clear", err_flag, 0);
  endtask

  task automatic t_saturate;
    cyc(1, 0, 0, 0, 0, 4'b0011);
    for (int k = 0; k < 65539; k++) cyc(1, 1, 1, 0, 1, 4'h0);
    cyc(0, 1, 1, 0, 1, 4'h0);
    check("R12", "xfer count saturates", txn_xfers, 65535);
    check("R12", "done after long burst", txn_done, 1);
    idle();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    idle();
    t_single();
    t_burst();
    t_waits();
    t_b2b();
    t_mhold();
    t_thold();
    t_rsvd();
    t_idle_rdy();
    t_saturate();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule